// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and IRQ Controller

This block holds the interrupt state of a real-time clock. Three event generators outside the block each send a one-cycle pulse: periodic, alarm and update-ended. Every pulse sets a sticky flag in a status register, whether or not that source is enabled. Software can therefore poll the flags with all interrupts disabled, or it can enable any subset of sources through a control register. An active-low interrupt line is asserted while any source has both its flag and its enable set, and the status register carries a summary bit that shows the same condition.

Software acknowledges interrupts by reading the status register over a simple register bus. A read lasts as long as a read strobe is held high. The status value is captured on the first cycle of the strobe and does not change for the rest of the read. Events that arrive while the read is in progress are kept aside, so none is lost. On the first cycle after the strobe falls, the flags that were read are cleared and any held events are merged into the register.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: The status register (address STAT_ADDR) reports the periodic flag in bit 6, the alarm flag in bit 5 and the update-ended flag in bit 4.
- R2: A one-cycle pulse on an event input sets its flag from the next cycle on, whatever the state of its enable bit.
- R3: The control register (address CTRL_ADDR) holds the periodic enable in bit 6, the alarm enable in bit 5 and the update-ended enable in bit 4. A source whose enable is 0 never drives irq_n low.
- R4: irq_n is 0 exactly when at least one source has both its flag and its enable set, and 1 otherwise.
- R5: Status bit 7 reads 1 exactly when irq_n is low at the start of the read. Status bits 3:0 always read 0.
- R6: Writing 1 to the enable of a source whose flag is already set drives irq_n low from the cycle after the write.
- R7: After a status read, every flag the read returned is cleared, from the second cycle after the strobe falls. Status bit 7 and irq_n then follow the cleared flags.
- R8: bus_rdata holds the value captured on the first strobe cycle for the whole read. An event that arrives while the strobe is high is held, and it becomes a set flag only once the read has ended.
- R9: A write to the status register changes no flag.
- R10: A read of the control register returns the enables in bits 6:4 with every other bit 0. bus_rdata is 0 when no read is in progress.
- R11: After reset all flags and enables are 0, irq_n is 1 and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, held high for the whole read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_alarm | input | 1 | Alarm event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench targets three timing cases. The first is an event that arrives during a multi-cycle read: a design without the holding path would either lose the event or change bus_rdata in the middle of the read. The second is an event that lands in the single cycle after the strobe falls, where the clear and the merge happen together: a design that clears after merging drops that event. The third is enabling a source whose flag was set earlier while it was disabled: irq_n must fall at once, and a design that only reacts to new events would leave it high. The bench also writes all ones to the status register to check that the write is ignored, and it sets several flags at once to check the position of each flag bit.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   localparam int NSRC     = 3;   // periodic, alarm, update-ended
   localparam int SRC_LSB  = 4;   // lowest flag / enable bit position
   localparam int IRQF_BIT = 7;   // summary bit in the status image
   localparam int SRC_PER  = 2;   // vector index of each source
   localparam int SRC_ALM  = 1;
   localparam int SRC_UPD  = 0;
   typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/rtc_irq_rd_seq.sv
module rtc_irq_rd_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic sta_rd,
   output logic rd_first,
   output logic rd_end
);
   logic rd_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_prev_q <= 1'b0;
      else        rd_prev_q <= sta_rd;
   end

   assign rd_first = sta_rd & ~rd_prev_q;
   assign rd_end   = rd_prev_q & ~sta_rd;
endmodule

// File: rtl/rtc_irq_flag_cell.sv
module rtc_irq_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   input  logic rd_act,
   input  logic rd_end,
   output logic flag,
   output logic pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         pend <= 1'b0;
      end else if (rd_end) begin
         flag <= pend | ev;   // clear what was read, merge what waited
         pend <= 1'b0;
      end else if (rd_act) begin
         pend <= pend | ev;   // flag frozen while the read is open
      end else begin
         flag <= flag | ev;
      end
   end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
   import rtc_irq_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int STAT_ADDR = 2,
   parameter int CTRL_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_periodic,
   input  logic              ev_alarm,
   input  logic              ev_update,
   output logic              irq_n
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   if (DATA_W < IRQF_BIT + 1) begin : g_bad_width
      $error("rtc_irq_ctrl: DATA_W must hold bit %0d", IRQF_BIT);
   end
   if (STAT_ADDR == CTRL_ADDR) begin : g_bad_addr
      $error("rtc_irq_ctrl: status and control addresses collide");
   end
   if (STAT_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_range
      $error("rtc_irq_ctrl: address does not fit ADDR_W");
   end

   logic     sta_rd, ctrl_rd, ctrl_wr;
   logic     rd_first, rd_end;
   logic     irq_act;
   src_vec_t ev_vec, flag_q, pend_q, en_q;
   logic [DATA_W-1:0] live_img, snap_q, ctrl_img;

   assign sta_rd  = bus_rd & (bus_addr == STAT_A);
   assign ctrl_rd = bus_rd & (bus_addr == CTRL_A);
   assign ctrl_wr = bus_wr & (bus_addr == CTRL_A);

   assign ev_vec[SRC_PER] = ev_periodic;
   assign ev_vec[SRC_ALM] = ev_alarm;
   assign ev_vec[SRC_UPD] = ev_update;

   rtc_irq_rd_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .sta_rd   (sta_rd),
      .rd_first (rd_first),
      .rd_end   (rd_end)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      rtc_irq_flag_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .ev     (ev_vec[i]),
         .rd_act (sta_rd),
         .rd_end (rd_end),
         .flag   (flag_q[i]),
         .pend   (pend_q[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (ctrl_wr) en_q <= bus_wdata[SRC_LSB +: NSRC];
   end

   assign irq_act = |(flag_q & en_q);
   assign irq_n   = ~irq_act;

   always_comb begin
      live_img = '0;
      live_img[IRQF_BIT] = irq_act;
      live_img[SRC_LSB +: NSRC] = flag_q;
      ctrl_img = '0;
      ctrl_img[SRC_LSB +: NSRC] = en_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        snap_q <= '0;
      else if (rd_first) snap_q <= live_img;
   end

   always_comb begin
      if (sta_rd)       bus_rdata = rd_first ? live_img : snap_q;
      else if (ctrl_rd) bus_rdata = ctrl_img;
      else              bus_rdata = '0;
   end
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sta_rd,
   input logic       rd_first,
   input logic       rd_end,
   input logic [7:0] bus_rdata,
   input logic       irq_n,
   input logic [2:0] flag_q,
   input logic [2:0] pend_q,
   input logic [2:0] en_q,
   input logic [2:0] ev_vec
);
   assert_summary_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_first |-> (bus_rdata[7] == !irq_n && bus_rdata[3:0] == 4'b0));

   assert_read_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sta_rd && !rd_first) |-> $stable(bus_rdata));

   assert_flags_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sta_rd |=> $stable(flag_q));

   assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_end && pend_q == 3'b0 && ev_vec == 3'b0) |=> (flag_q == 3'b0 && irq_n));

   assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == 3'b0) |-> irq_n);

   assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sta_rd && !rd_end && ev_vec[1]) |=> flag_q[1]);

   assert_irq_from_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & en_q) != 3'b0) |-> !irq_n);
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sta_rd    (sta_rd),
   .rd_first  (rd_first),
   .rd_end    (rd_end),
   .bus_rdata (bus_rdata[7:0]),
   .irq_n     (irq_n),
   .flag_q    (flag_q),
   .pend_q    (pend_q),
   .en_q      (en_q),
   .ev_vec    (ev_vec)
);

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb;
   localparam int STA = 2;
   localparam int CTL = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ev_p = 1'b0, ev_a = 1'b0, ev_u = 1'b0;
   logic       irq_n;

   int checks = 0, errors = 0, cycles = 0;
   string cur_req = "R11";

   always #10 clk = ~clk;   // 50 MHz

   rtc_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_periodic(ev_p), .ev_alarm(ev_a), .ev_update(ev_u), .irq_n(irq_n)
   );

   // behavioural reference: bit 2 periodic, bit 1 alarm, bit 0 update-ended
   int m_fl = 0, m_pend = 0, m_en = 0, m_snap = 0;
   bit m_inrd = 0;

   function automatic int img_status();
      return (((m_fl & m_en) != 0) ? 128 : 0) | (m_fl << 4);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_fl = 0; m_pend = 0; m_en = 0; m_snap = 0; m_inrd = 0;
      end else begin
         bit rd_now;
         int ev;
         rd_now = bus_rd && bus_addr == STA;
         ev = (ev_p ? 4 : 0) | (ev_a ? 2 : 0) | (ev_u ? 1 : 0);
         if (rd_now && !m_inrd) m_snap = img_status();
         if (m_inrd && !rd_now) begin
            m_fl = m_pend | ev; m_pend = 0;
         end else if (rd_now) m_pend = m_pend | ev;
         else m_fl = m_fl | ev;
         if (bus_wr && bus_addr == CTL) m_en = (bus_wdata >> 4) & 7;
         m_inrd = rd_now;
      end
   end

   always @(negedge clk) begin
      int exp_rd;
      bit exp_irq;
      exp_irq = ((m_fl & m_en) == 0);
      if (rst_n && bus_rd && bus_addr == STA)
         exp_rd = m_inrd ? m_snap : img_status();
      else if (rst_n && bus_rd && bus_addr == CTL)
         exp_rd = m_en << 4;
      else exp_rd = 0;
      if (!rst_n) exp_irq = 1'b1;
      checks++;
      if (irq_n !== exp_irq) begin
         errors++;
         $display("FAIL R4 (%s) irq_n actual=%b expected=%b t=%0t", cur_req, irq_n, exp_irq, $time);
      end
      checks++;
      if (bus_rdata !== 8'(exp_rd)) begin
         errors++;
         $display("FAIL %s bus_rdata actual=%h expected=%h t=%0t", cur_req, bus_rdata, 8'(exp_rd), $time);
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   task automatic drive(input int a, input bit rd, input bit wr, input int wd,
                        input bit p, input bit al, input bit u);
      @(posedge clk); #2;
      bus_addr = 4'(a); bus_rd = rd; bus_wr = wr; bus_wdata = 8'(wd);
      ev_p = p; ev_a = al; ev_u = u;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic rd_status(input int len);
      for (int i = 0; i < len; i++) drive(STA, 1, 0, 0, 0, 0, 0);
      idle(2);
   endtask

   initial begin
      cur_req = "R11";
      idle(3);
      @(posedge clk); #2 rst_n = 1'b1;
      idle(2);
      // R2 / R3: alarm event with enables off sets flag, no irq
      cur_req = "R2";
      drive(0, 0, 0, 0, 0, 1, 0); idle(2);
      cur_req = "R1";
      rd_status(3);             // expect 0x20 then cleared
      // R3: ctrl write and readback, periodic enabled only
      cur_req = "R10";
      drive(CTL, 0, 1, 8'h40, 0, 0, 0); drive(CTL, 1, 0, 0, 0, 0, 0); idle(1);
      cur_req = "R3";
      drive(0, 0, 0, 0, 0, 1, 1); idle(2);   // alarm+update flagged, irq stays high
      // R6: enable alarm while flag is set
      cur_req = "R6";
      drive(CTL, 0, 1, 8'h60, 0, 0, 0); idle(2);
      cur_req = "R5";
      rd_status(2);             // expect 0xB0
      cur_req = "R7";
      idle(2);
      // R1: all three flags set at once
      cur_req = "R1";
      drive(0, 0, 0, 0, 1, 1, 1); idle(1);
      rd_status(1);             // expect 0xF0
      // R8: event during a multi-cycle read is held
      cur_req = "R8";
      drive(0, 0, 0, 0, 0, 0, 1); idle(1);
      drive(STA, 1, 0, 0, 0, 0, 0);
      drive(STA, 1, 0, 0, 1, 0, 0);
      drive(STA, 1, 0, 0, 0, 1, 0);
      drive(STA, 1, 0, 0, 0, 0, 0);
      idle(2);
      rd_status(2);             // expect 0xE0 (periodic and alarm held)
      // R8: event in the cycle after strobe falls survives the clear
      drive(0, 0, 0, 0, 0, 1, 0);
      drive(STA, 1, 0, 0, 0, 0, 0);
      drive(STA, 1, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 1);
      idle(2);
      rd_status(1);
      // R9: status write ignored
      cur_req = "R9";
      drive(0, 0, 0, 0, 1, 0, 0); idle(1);
      drive(STA, 0, 1, 8'hFF, 0, 0, 0); idle(1);
      rd_status(2);
      drive(CTL, 0, 1, 8'h00, 0, 0, 0);
      drive(CTL, 1, 0, 0, 0, 0, 0);
      // R7: back-to-back reads with a one-cycle gap
      cur_req = "R7";
      drive(0, 0, 0, 0, 1, 1, 0);
      drive(STA, 1, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 0);
      drive(STA, 1, 0, 0, 0, 0, 0);
      idle(3);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule